// File: doc/BRIEF.md
# Crate-Bus Channel Memory Controller

This block sits behind the dataway interface of a sixteen-channel digitizer module. It decodes a function code and subaddress from each command strobe. It keeps one 12-bit word per channel, which the host can write and read back. Every read word carries a channel tag in its upper bits, so software can confirm which channel answered. The conversion engine uses a separate write port to drop its results straight into the same storage.

The block also holds four test-pattern slots. They are reached through an indirection: one command arms the selection, and the next load command fills one slot. A digital-test command copies the most recently loaded pattern into every channel. Other commands raise one-cycle strobes for the front-end test at two stimulus levels, for a module clear and for a hit-register clear. An initialize input puts every register back into its power-up state.

Responses are registered. The accepted flag, the read word and the strobes appear in the cycle after the command.

Top module: `chmem_ctrl`

## Requirements
- R1: A command with function 16 and subaddress n (0..15) stores write-data bits 11:0 into channel n. The upper write-data bits are discarded, and the accepted flag is high in the next cycle.
- R2: A command with function 0 and subaddress n returns, in the next cycle, a 16-bit word. Bits 15:12 hold n, bits 11:0 hold channel n, and the accepted flag is high. The read word holds its value until the next accepted read.
- R3: Function 17 with subaddress 4 arms the pattern selection. The next function 20 command with subaddress 0..3 loads write-data bits 11:0 into that slot and disarms. A function 20 command made while disarmed, or with subaddress above 3, changes nothing and is not accepted. An armed selection survives such a rejected load.
- R4: Function 25 with subaddress 0 copies the most recently loaded slot into all sixteen channels. It also pulses the digital-test strobe for one cycle.
- R5: Function 25 with subaddress 1 pulses the normal-level front-end strobe, and with subaddress 2 the double-level front-end strobe. At most one strobe is high in any cycle.
- R6: Function 9 (any subaddress) pulses the clear strobe. Function 11 with subaddress 3 pulses the hit-clear strobe.
- R7: Any other function or subaddress combination leaves the accepted flag low and changes no state or output.
- R8: A conversion-engine write stores its data into the addressed channel. When it hits the same channel as a host write in the same cycle, the conversion data is kept.
- R9: While initialize is high, no command takes effect. After it, all channels, all slots, the arm state and the active slot are zero, and the accepted flag, read word and strobes are low.
- R10: After reset, the accepted flag, read word and all strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous initialize to power-up state |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_func_i | input | 5 | Function code |
| cmd_sub_i | input | 4 | Subaddress |
| cmd_wdata_i | input | 16 | Write data |
| conv_we_i | input | 1 | Conversion-engine write enable |
| conv_ch_i | input | 4 | Conversion-engine channel index |
| conv_data_i | input | 12 | Conversion-engine data |
| cmd_rdata_o | output | 16 | Read word: channel tag over channel data |
| cmd_ack_o | output | 1 | Command accepted (one cycle after command) |
| dig_test_o | output | 1 | Digital-test strobe |
| fe_test_lo_o | output | 1 | Front-end test strobe, normal level |
| fe_test_hi_o | output | 1 | Front-end test strobe, double level |
| clear_o | output | 1 | Module-clear strobe |
| hit_clr_o | output | 1 | Hit-register clear strobe |

## Verification
The hardest state to reach from the ports is a host write and a conversion write landing on the same channel in one clock. The bench raises both write enables in the same cycle, pointed at one index, and reads that channel back. It also checks a pair aimed at different channels to show that both land. The arm state has no output of its own, so it is exposed indirectly. A load is rejected after the arm has been consumed, an initialize follows a pending arm, and a rejected out-of-range load leaves the arm standing. Each case then shows through the accepted flag and through the pattern a later digital test copies into a channel.

// File: rtl/chmem_pkg.sv
package chmem_pkg;

    localparam logic [4:0] FN_READ   = 5'd0;
    localparam logic [4:0] FN_CLEAR  = 5'd9;
    localparam logic [4:0] FN_HITCLR = 5'd11;
    localparam logic [4:0] FN_WRITE  = 5'd16;
    localparam logic [4:0] FN_SELECT = 5'd17;
    localparam logic [4:0] FN_LOAD   = 5'd20;
    localparam logic [4:0] FN_TEST   = 5'd25;

    localparam logic [3:0] SA_PATSEL = 4'd4;
    localparam logic [3:0] SA_HIT    = 4'd3;
    localparam logic [3:0] SA_DIG    = 4'd0;
    localparam logic [3:0] SA_FE_LO  = 4'd1;
    localparam logic [3:0] SA_FE_HI  = 4'd2;

    typedef struct packed {
        logic mem_wr;
        logic mem_rd;
        logic arm;
        logic load;
        logic dig;
        logic fe_lo;
        logic fe_hi;
        logic clr;
        logic hclr;
    } fire_t;

endpackage

// File: rtl/chmem_decode.sv
module chmem_decode
    import chmem_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int NSLOT = 4
) (
    input  logic       valid_i,
    input  logic [4:0] func_i,
    input  logic [3:0] sub_i,
    input  logic       armed_i,
    output fire_t      fire_o
);

    logic sub_in_mem;
    logic sub_in_slot;

    always_comb begin
        sub_in_mem  = int'(sub_i) < NCH;
        sub_in_slot = int'(sub_i) < NSLOT;
    end

    always_comb begin
        fire_o = '0;
        if (valid_i) begin
            case (func_i)
                FN_READ:   fire_o.mem_rd = sub_in_mem;
                FN_WRITE:  fire_o.mem_wr = sub_in_mem;
                FN_CLEAR:  fire_o.clr    = 1'b1;
                FN_HITCLR: fire_o.hclr   = (sub_i == SA_HIT);
                FN_SELECT: fire_o.arm    = (sub_i == SA_PATSEL);
                FN_LOAD:   fire_o.load   = armed_i && sub_in_slot;
                FN_TEST: begin
                    fire_o.dig   = (sub_i == SA_DIG);
                    fire_o.fe_lo = (sub_i == SA_FE_LO);
                    fire_o.fe_hi = (sub_i == SA_FE_HI);
                end
                default: fire_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/chmem_testreg.sv
module chmem_testreg #(
    parameter int DW    = 12,
    parameter int NSLOT = 4,
    localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic          arm_i,
    input  logic          load_i,
    input  logic [SW-1:0] slot_i,
    input  logic [DW-1:0] data_i,
    output logic          armed_o,
    output logic [DW-1:0] pattern_o
);

    typedef struct packed {
        logic [NSLOT-1:0][DW-1:0] slots;
        logic                     armed;
        logic [SW-1:0]            active;
    } treg_t;

    treg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (init_i) begin
            st_d = '0;
        end else begin
            if (arm_i) begin
                st_d.armed = 1'b1;
            end
            if (load_i) begin
                st_d.slots[slot_i] = data_i;
                st_d.active        = slot_i;
                st_d.armed         = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed_o   = st_q.armed;
    assign pattern_o = st_q.slots[st_q.active];

    AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !armed_o) else $error("arm survived load"); // R3
    AST_SLOTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !init_i) |=> $stable(st_q.slots)) else $error("slot changed"); // R3
    AST_INIT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (!armed_o && pattern_o == '0)) else $error("init left state"); // R9

endmodule

// File: rtl/chmem_store.sv
module chmem_store #(
    parameter int NCH  = 16,
    parameter int DW   = 12,
    localparam int AW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic          host_we_i,
    input  logic [AW-1:0] host_idx_i,
    input  logic [DW-1:0] host_data_i,
    input  logic          conv_we_i,
    input  logic [AW-1:0] conv_idx_i,
    input  logic [DW-1:0] conv_data_i,
    input  logic          copy_en_i,
    input  logic [DW-1:0] copy_data_i,
    input  logic [AW-1:0] rd_idx_i,
    output logic [DW-1:0] rd_word_o
);

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] mem;
    } store_t;

    store_t st_d, st_q;
    logic [DW-1:0] ch_next [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic conv_hit;
        logic host_hit;
        assign conv_hit = conv_we_i && (int'(conv_idx_i) == g);
        assign host_hit = host_we_i && (int'(host_idx_i) == g);
        assign ch_next[g] = conv_hit  ? conv_data_i :
                            host_hit  ? host_data_i :
                            copy_en_i ? copy_data_i :
                                        st_q.mem[g];
    end

    always_comb begin
        st_d = st_q;
        if (init_i) begin
            st_d = '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                st_d.mem[i] = ch_next[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_word_o = st_q.mem[rd_idx_i];

    AST_CONV_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_we_i && !init_i) |=> st_q.mem[$past(conv_idx_i)] == $past(conv_data_i))
        else $error("conversion write lost"); // R8
    AST_HOST_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we_i && !init_i && !(conv_we_i && conv_idx_i == host_idx_i))
        |=> st_q.mem[$past(host_idx_i)] == $past(host_data_i))
        else $error("host write lost"); // R1

endmodule

// File: rtl/chmem_ctrl.sv
module chmem_ctrl
    import chmem_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int DW    = 12,
    parameter int NSLOT = 4,
    localparam int AW   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int RW   = 4 + DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic          cmd_valid_i,
    input  logic [4:0]    cmd_func_i,
    input  logic [3:0]    cmd_sub_i,
    input  logic [15:0]   cmd_wdata_i,
    input  logic          conv_we_i,
    input  logic [3:0]    conv_ch_i,
    input  logic [DW-1:0] conv_data_i,
    output logic [RW-1:0] cmd_rdata_o,
    output logic          cmd_ack_o,
    output logic          dig_test_o,
    output logic          fe_test_lo_o,
    output logic          fe_test_hi_o,
    output logic          clear_o,
    output logic          hit_clr_o
);

    typedef struct packed {
        logic [RW-1:0] rdata;
        logic          ack;
        logic          dig;
        logic          fe_lo;
        logic          fe_hi;
        logic          clr;
        logic          hclr;
    } resp_t;

    resp_t         rs_d, rs_q;
    fire_t         fire;
    logic          armed;
    logic [DW-1:0] pattern;
    logic [DW-1:0] rd_word;

    chmem_decode #(.NCH(NCH), .NSLOT(NSLOT)) u_dec (
        .valid_i (cmd_valid_i && !init_i),
        .func_i  (cmd_func_i),
        .sub_i   (cmd_sub_i),
        .armed_i (armed),
        .fire_o  (fire)
    );

    chmem_testreg #(.DW(DW), .NSLOT(NSLOT)) u_treg (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_i    (init_i),
        .arm_i     (fire.arm),
        .load_i    (fire.load),
        .slot_i    (cmd_sub_i[SW-1:0]),
        .data_i    (cmd_wdata_i[DW-1:0]),
        .armed_o   (armed),
        .pattern_o (pattern)
    );

    chmem_store #(.NCH(NCH), .DW(DW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (init_i),
        .host_we_i   (fire.mem_wr),
        .host_idx_i  (cmd_sub_i[AW-1:0]),
        .host_data_i (cmd_wdata_i[DW-1:0]),
        .conv_we_i   (conv_we_i),
        .conv_idx_i  (conv_ch_i[AW-1:0]),
        .conv_data_i (conv_data_i),
        .copy_en_i   (fire.dig),
        .copy_data_i (pattern),
        .rd_idx_i    (cmd_sub_i[AW-1:0]),
        .rd_word_o   (rd_word)
    );

    always_comb begin
        rs_d       = rs_q;
        rs_d.ack   = |fire;
        rs_d.dig   = fire.dig;
        rs_d.fe_lo = fire.fe_lo;
        rs_d.fe_hi = fire.fe_hi;
        rs_d.clr   = fire.clr;
        rs_d.hclr  = fire.hclr;
        if (fire.mem_rd) begin
            rs_d.rdata = {cmd_sub_i, rd_word};
        end
        if (init_i) begin
            rs_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign cmd_rdata_o  = rs_q.rdata;
    assign cmd_ack_o    = rs_q.ack;
    assign dig_test_o   = rs_q.dig;
    assign fe_test_lo_o = rs_q.fe_lo;
    assign fe_test_hi_o = rs_q.fe_hi;
    assign clear_o      = rs_q.clr;
    assign hit_clr_o    = rs_q.hclr;

    AST_ACK_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ack_o |-> $past(cmd_valid_i) && !$past(init_i)) else $error("stray ack"); // R7
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dig_test_o, fe_test_lo_o, fe_test_hi_o, clear_o, hit_clr_o}))
        else $error("strobes overlap"); // R5
    AST_READ_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && !init_i && cmd_func_i == FN_READ)
        |=> cmd_rdata_o[RW-1:RW-4] == $past(cmd_sub_i)) else $error("bad tag"); // R2
    AST_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (!cmd_ack_o && cmd_rdata_o == '0 && !clear_o && !dig_test_o))
        else $error("init not quiet"); // R9

endmodule

// File: tb/tb_chmem_ctrl.sv
module tb_chmem_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_i = 1'b0;
    logic        cmd_valid_i = 1'b0;
    logic [4:0]  cmd_func_i = '0;
    logic [3:0]  cmd_sub_i = '0;
    logic [15:0] cmd_wdata_i = '0;
    logic        conv_we_i = 1'b0;
    logic [3:0]  conv_ch_i = '0;
    logic [11:0] conv_data_i = '0;
    logic [15:0] cmd_rdata_o;
    logic        cmd_ack_o, dig_test_o, fe_test_lo_o, fe_test_hi_o, clear_o, hit_clr_o;

    int n_chk = 0;
    int n_fail = 0;
    logic        s_ack;
    logic [15:0] s_rd;
    logic [4:0]  s_stb;

    always #5 clk = ~clk;

    chmem_ctrl dut (
        .clk(clk), .rst_n(rst_n), .init_i(init_i),
        .cmd_valid_i(cmd_valid_i), .cmd_func_i(cmd_func_i), .cmd_sub_i(cmd_sub_i),
        .cmd_wdata_i(cmd_wdata_i), .conv_we_i(conv_we_i), .conv_ch_i(conv_ch_i),
        .conv_data_i(conv_data_i), .cmd_rdata_o(cmd_rdata_o), .cmd_ack_o(cmd_ack_o),
        .dig_test_o(dig_test_o), .fe_test_lo_o(fe_test_lo_o), .fe_test_hi_o(fe_test_hi_o),
        .clear_o(clear_o), .hit_clr_o(hit_clr_o)
    );

    // strobe vector order: {dig, fe_lo, fe_hi, clr, hclr}
    localparam logic [4:0] ST_DIG = 5'b10000, ST_LO = 5'b01000, ST_HI = 5'b00100,
                           ST_CLR = 5'b00010, ST_HCLR = 5'b00001;

    // {func[42:38], sub[37:34], wdata[33:18], ack[17], chk_rd[16], rdata[15:0]}
    localparam logic [42:0] VEC [0:9] = '{
        {5'd16, 4'd0,  16'h0ABC, 1'b1, 1'b0, 16'h0000},
        {5'd16, 4'd5,  16'hF123, 1'b1, 1'b0, 16'h0000},
        {5'd16, 4'd15, 16'h0FFF, 1'b1, 1'b0, 16'h0000},
        {5'd0,  4'd0,  16'h0000, 1'b1, 1'b1, 16'h0ABC},
        {5'd0,  4'd5,  16'h0000, 1'b1, 1'b1, 16'h5123},
        {5'd0,  4'd15, 16'h0000, 1'b1, 1'b1, 16'hFFFF},
        {5'd0,  4'd3,  16'h0000, 1'b1, 1'b1, 16'h3000},
        {5'd1,  4'd0,  16'h1234, 1'b0, 1'b1, 16'h3000},
        {5'd17, 4'd2,  16'h0000, 1'b0, 1'b1, 16'h3000},
        {5'd25, 4'd3,  16'h0000, 1'b0, 1'b1, 16'h3000}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [4:0] f, input logic [3:0] s, input logic [15:0] d);
        @(negedge clk);
        cmd_valid_i = 1'b1; cmd_func_i = f; cmd_sub_i = s; cmd_wdata_i = d;
        @(posedge clk);
        #1;
        s_ack = cmd_ack_o; s_rd = cmd_rdata_o;
        s_stb = {dig_test_o, fe_test_lo_o, fe_test_hi_o, clear_o, hit_clr_o};
        cmd_valid_i = 1'b0; conv_we_i = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        @(posedge clk);
        #1;
        s_ack = cmd_ack_o;
        s_stb = {dig_test_o, fe_test_lo_o, fe_test_hi_o, clear_o, hit_clr_o};
        conv_we_i = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] s, input logic [15:0] exp);
        cmd(5'd0, s, 16'h0);
        chk(req, s_rd, exp);
    endtask

    task automatic do_init();
        @(negedge clk);
        init_i = 1'b1;
        @(posedge clk);
        #1;
        init_i = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #22 rst_n = 1'b1;
        // R10 reset state
        @(negedge clk);
        chk("R10 ack", {15'd0, cmd_ack_o}, 16'h0);
        chk("R10 rdata", cmd_rdata_o, 16'h0);
        chk("R10 strobes", {11'd0, dig_test_o, fe_test_lo_o, fe_test_hi_o, clear_o, hit_clr_o}, 16'h0);

        // vector table: R1, R2, R7
        for (int i = 0; i < 10; i++) begin
            cmd(VEC[i][42:38], VEC[i][37:34], VEC[i][33:18]);
            chk("R1/R2/R7 ack", {15'd0, s_ack}, {15'd0, VEC[i][17]});
            if (VEC[i][16]) chk("R2/R7 rdata", s_rd, VEC[i][15:0]);
        end
        rd_chk("R7 ch3 untouched", 4'd3, 16'h3000);

        // R1 all channels
        for (int c = 0; c < 16; c++) cmd(5'd16, 4'(c), 16'(c * 37 + 100));
        for (int c = 0; c < 16; c++) rd_chk("R1 sweep", 4'(c), {4'(c), 12'(c * 37 + 100)});

        // R3 unarmed load rejected
        cmd(5'd20, 4'd1, 16'h0249);
        chk("R3 unarmed ack", {15'd0, s_ack}, 16'h0);
        cmd(5'd17, 4'd4, 16'h0);
        chk("R3 arm ack", {15'd0, s_ack}, 16'h1);
        cmd(5'd20, 4'd1, 16'h0249);
        chk("R3 load ack", {15'd0, s_ack}, 16'h1);
        cmd(5'd20, 4'd2, 16'h0555);
        chk("R3 consumed ack", {15'd0, s_ack}, 16'h0);
        // R4 digital test copies slot 1
        cmd(5'd25, 4'd0, 16'h0);
        chk("R4 dig strobe", {11'd0, s_stb}, {11'd0, ST_DIG});
        idle();
        chk("R4 strobe one cycle", {11'd0, s_stb}, 16'h0);
        rd_chk("R4 ch7 pattern", 4'd7, 16'h7249);
        rd_chk("R4 ch15 pattern", 4'd15, 16'hF249);
        // R3 out-of-range slot rejected, arm kept
        cmd(5'd17, 4'd4, 16'h0);
        cmd(5'd20, 4'd5, 16'h0777);
        chk("R3 bad slot ack", {15'd0, s_ack}, 16'h0);
        cmd(5'd20, 4'd2, 16'h00AA);
        chk("R3 arm kept ack", {15'd0, s_ack}, 16'h1);
        cmd(5'd25, 4'd0, 16'h0);
        rd_chk("R4 slot2 copy", 4'd0, 16'h00AA);

        // R5 front-end strobes
        cmd(5'd25, 4'd1, 16'h0);
        chk("R5 fe lo", {11'd0, s_stb}, {11'd0, ST_LO});
        cmd(5'd25, 4'd2, 16'h0);
        chk("R5 fe hi", {11'd0, s_stb}, {11'd0, ST_HI});
        // R6 clear strobes
        cmd(5'd9, 4'd7, 16'h0);
        chk("R6 clear", {11'd0, s_stb}, {11'd0, ST_CLR});
        cmd(5'd11, 4'd3, 16'h0);
        chk("R6 hit clear", {11'd0, s_stb}, {11'd0, ST_HCLR});
        cmd(5'd11, 4'd0, 16'h0);
        chk("R7 hit wrong sub strobes", {11'd0, s_stb}, 16'h0);
        chk("R7 hit wrong sub ack", {15'd0, s_ack}, 16'h0);

        // R8 conversion port
        @(negedge clk);
        conv_we_i = 1'b1; conv_ch_i = 4'd4; conv_data_i = 12'h777;
        idle();
        rd_chk("R8 conv alone", 4'd4, 16'h4777);
        conv_we_i = 1'b1; conv_ch_i = 4'd6; conv_data_i = 12'h222;
        cmd(5'd16, 4'd6, 16'h0111);
        rd_chk("R8 same channel conv wins", 4'd6, 16'h6222);
        conv_we_i = 1'b1; conv_ch_i = 4'd9; conv_data_i = 12'h444;
        cmd(5'd16, 4'd8, 16'h0333);
        rd_chk("R8 host other channel", 4'd8, 16'h8333);
        rd_chk("R8 conv other channel", 4'd9, 16'h9444);

        // R9 initialize
        cmd(5'd17, 4'd4, 16'h0);
        do_init();
        chk("R9 rdata cleared", cmd_rdata_o, 16'h0);
        chk("R9 ack low", {15'd0, cmd_ack_o}, 16'h0);
        rd_chk("R9 memory zero", 4'd4, 16'h4000);
        cmd(5'd20, 4'd0, 16'h0123);
        chk("R9 arm cancelled", {15'd0, s_ack}, 16'h0);
        cmd(5'd16, 4'd9, 16'h0005);
        cmd(5'd25, 4'd0, 16'h0);
        rd_chk("R9 slots zero", 4'd9, 16'h9000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule